// File: doc/BRIEF.md
# Taken-Branch Table Predication Unit

This unit sits inside one instruction station of a wide, time-ordered execution window. It decides, from branch outcomes seen on a predicate broadcast bus, whether the non-branch instruction held in the station may run. Every broadcast carries the branch's time tag, its predicate (taken or not taken) and its target address. The unit only reacts to broadcasts from branches older than its own station, meaning the broadcast tag is numerically smaller than the station tag. For each such broadcast it compares the target with the station's own instruction address.

When the addresses differ, the station lies inside the branch's control domain. A taken predicate then records the branch tag in a small table of four entries. The instruction is held disabled while any entry is valid. A not-taken predicate for a recorded tag removes that tag again. When the addresses match, the station sits just past the branch's domain. It leaves its table alone and asks, one cycle later, to rebroadcast the branch tag as a cancelling predicate. Cancelling predicates snooped from other stations clear a matching entry, which releases younger instructions from that branch.

The table never grows with the window. If a taken branch finds no free entry, a sticky overflow flag keeps the instruction disabled until the station is loaded with a new instruction. Loading sets the station's tag and address and empties the table.

Top module: `brtab_pred_unit`

## Requirements
- R1: After reset, and on the cycle after a load, enable_o is 1, overflow_o is 0 and cancel_req_o is 0.
- R2: A predicate broadcast whose tag is equal to or larger than the station tag changes nothing: no table change and no rebroadcast request.
- R3: A taken predicate from an older branch, with a target that differs from the station address, records the tag, and enable_o reads 0 after the next rising edge.
- R4: A taken predicate for a tag already recorded uses no further entry, so four distinct tags still fit after repeats.
- R5: A not-taken predicate from an older branch, with a target that differs from the station address, clears the entry holding that tag.
- R6: A cancelling predicate clears the entry whose tag matches it. A cancelling tag that is not recorded has no effect.
- R7: A taken predicate from an older branch whose target equals the station address leaves the table unchanged. It raises cancel_req_o for exactly the following cycle, with cancel_tag_o equal to the branch tag. A not-taken predicate with a matching target raises no request.
- R8: enable_o is 1 exactly when no entry is valid and overflow is clear.
- R9: A taken insert of a new tag with all four entries valid sets overflow_o. overflow_o stays set, and enable_o stays 0, through any cancels and clears until the next load.
- R10: When a cancelling predicate and a predicate broadcast arrive in the same cycle, the cancel is applied first and the predicate is applied to the result.
- R11: A load takes priority over every broadcast arriving in the same cycle, and those broadcasts are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Station receives a new instruction |
| load_tag_i | input | TAG_W | Time tag of the loaded station |
| load_addr_i | input | ADDR_W | Instruction address of the loaded station |
| pred_valid_i | input | 1 | Predicate broadcast present |
| pred_tag_i | input | TAG_W | Time tag of the broadcasting branch |
| pred_taken_i | input | 1 | Predicate value, 1 = taken |
| pred_target_i | input | ADDR_W | Branch target address |
| cancel_valid_i | input | 1 | Cancelling predicate present |
| cancel_tag_i | input | TAG_W | Branch tag being cancelled |
| enable_o | output | 1 | Instruction may execute |
| overflow_o | output | 1 | Sticky table overflow |
| cancel_req_o | output | 1 | Request to rebroadcast a cancelling predicate |
| cancel_tag_o | output | TAG_W | Branch tag to cancel |

## Verification
All state changes take effect at the first rising edge after a stimulus. enable_o and overflow_o are decoded directly from registered state, so they show the new value right after that edge. cancel_req_o and cancel_tag_o come from a register and are valid only for the cycle that follows the broadcast. The bench applies inputs at the falling edge, waits for the next rising edge, updates its own model of the set of recorded tags, and samples every output one nanosecond later. Each check is therefore made in the single cycle where its result is due.

// File: rtl/brtab_pkg.sv
package brtab_pkg;
    localparam int BRTAB_DEF_ENTRIES = 4;
    localparam int BRTAB_DEF_TAG_W   = 4;
    localparam int BRTAB_DEF_ADDR_W  = 8;

    // What one predicate broadcast does to the station in a cycle
    typedef enum logic [2:0] {
        PACT_NONE,
        PACT_INSERT,
        PACT_KEEP,
        PACT_CLEAR,
        PACT_REBCAST,
        PACT_OVERFLOW
    } pred_act_e;
endpackage

// File: rtl/brtab_match.sv
module brtab_match #(
    parameter int ENTRIES = brtab_pkg::BRTAB_DEF_ENTRIES,
    parameter int TAG_W   = brtab_pkg::BRTAB_DEF_TAG_W
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              cmp_tag,
    output logic [ENTRIES-1:0]            hit
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit[g] = vld[g] && (tags[g] == cmp_tag);
    end
endmodule

// File: rtl/brtab_alloc.sv
module brtab_alloc #(
    parameter int ENTRIES = brtab_pkg::BRTAB_DEF_ENTRIES
) (
    input  logic [ENTRIES-1:0] vld,
    output logic [ENTRIES-1:0] grant,
    output logic               any_free
);
    logic [ENTRIES-1:0] free;
    logic [ENTRIES:0]   seen;

    assign free    = ~vld;
    assign seen[0] = 1'b0;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_pick
        assign grant[g]  = free[g] && !seen[g];
        assign seen[g+1] = seen[g] || free[g];
    end
    assign any_free = seen[ENTRIES];
endmodule

// File: rtl/brtab_pred_unit.sv
module brtab_pred_unit #(
    parameter int ENTRIES = brtab_pkg::BRTAB_DEF_ENTRIES,
    parameter int TAG_W   = brtab_pkg::BRTAB_DEF_TAG_W,
    parameter int ADDR_W  = brtab_pkg::BRTAB_DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TAG_W-1:0]  load_tag_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              pred_valid_i,
    input  logic [TAG_W-1:0]  pred_tag_i,
    input  logic              pred_taken_i,
    input  logic [ADDR_W-1:0] pred_target_i,
    input  logic              cancel_valid_i,
    input  logic [TAG_W-1:0]  cancel_tag_i,
    output logic              enable_o,
    output logic              overflow_o,
    output logic              cancel_req_o,
    output logic [TAG_W-1:0]  cancel_tag_o
);
    import brtab_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][TAG_W-1:0] tags;
        logic                          ovf;
        logic [TAG_W-1:0]              own_tag;
        logic [ADDR_W-1:0]             own_addr;
        logic                          creq;
        logic [TAG_W-1:0]              ctag;
    } state_t;

    state_t st_q, st_d;

    logic [ENTRIES-1:0] cancel_hit;
    logic [ENTRIES-1:0] vld_after_cancel;
    logic [ENTRIES-1:0] pred_hit;
    logic [ENTRIES-1:0] pred_hit_raw;
    logic [ENTRIES-1:0] grant;
    logic               any_free;
    logic               older;
    logic               tgt_match;
    pred_act_e          act;

    brtab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cancel_match (
        .vld     (st_q.vld),
        .tags    (st_q.tags),
        .cmp_tag (cancel_tag_i),
        .hit     (cancel_hit)
    );

    assign vld_after_cancel = cancel_valid_i ? (st_q.vld & ~cancel_hit) : st_q.vld;

    brtab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_pred_match (
        .vld     (vld_after_cancel),
        .tags    (st_q.tags),
        .cmp_tag (pred_tag_i),
        .hit     (pred_hit)
    );

    brtab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_dup_probe (
        .vld     (st_q.vld),
        .tags    (st_q.tags),
        .cmp_tag (pred_tag_i),
        .hit     (pred_hit_raw)
    );

    brtab_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .vld      (vld_after_cancel),
        .grant    (grant),
        .any_free (any_free)
    );

    assign older     = pred_tag_i < st_q.own_tag;
    assign tgt_match = pred_target_i == st_q.own_addr;

    always_comb begin
        act = PACT_NONE;
        if (pred_valid_i && older) begin
            if (tgt_match) begin
                act = pred_taken_i ? PACT_REBCAST : PACT_NONE;
            end else if (pred_taken_i) begin
                if (|pred_hit)     act = PACT_KEEP;
                else if (any_free) act = PACT_INSERT;
                else               act = PACT_OVERFLOW;
            end else begin
                act = PACT_CLEAR;
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.creq = 1'b0;
        if (load_i) begin
            st_d.vld      = '0;
            st_d.ovf      = 1'b0;
            st_d.own_tag  = load_tag_i;
            st_d.own_addr = load_addr_i;
        end else begin
            st_d.vld = vld_after_cancel;
            unique case (act)
                PACT_INSERT: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (grant[i]) begin
                            st_d.vld[i]  = 1'b1;
                            st_d.tags[i] = pred_tag_i;
                        end
                    end
                end
                PACT_CLEAR:    st_d.vld  = vld_after_cancel & ~pred_hit;
                PACT_OVERFLOW: st_d.ovf  = 1'b1;
                PACT_REBCAST: begin
                    st_d.creq = 1'b1;
                    st_d.ctag = pred_tag_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o     = ~(|st_q.vld) && !st_q.ovf;
    assign overflow_o   = st_q.ovf;
    assign cancel_req_o = st_q.creq;
    assign cancel_tag_o = st_q.ctag;

    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (enable_o && !overflow_o && !cancel_req_o)); // R1

    AST_YOUNGER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_i && (pred_tag_i >= st_q.own_tag) && !load_i && !cancel_valid_i)
        |=> ($stable(st_q.vld) && !cancel_req_o)); // R2

    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pred_hit_raw)); // R4

    AST_TARGET_NO_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_i && older && tgt_match && !load_i && !cancel_valid_i)
        |=> $stable(st_q.vld)); // R7

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req_o |-> $past(pred_valid_i && pred_taken_i && !load_i)); // R7

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !load_i) |=> (overflow_o && !enable_o)); // R9
endmodule

// File: tb/brtab_pred_unit_bench.sv
`timescale 1ns/1ps
module brtab_pred_unit_bench;
    localparam int TW = 4;
    localparam int AW = 8;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [TW-1:0] load_tag_i = '0;
    logic [AW-1:0] load_addr_i = '0;
    logic          pred_valid_i = 1'b0;
    logic [TW-1:0] pred_tag_i = '0;
    logic          pred_taken_i = 1'b0;
    logic [AW-1:0] pred_target_i = '0;
    logic          cancel_valid_i = 1'b0;
    logic [TW-1:0] cancel_tag_i = '0;
    logic          enable_o, overflow_o, cancel_req_o;
    logic [TW-1:0] cancel_tag_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0]   m_set;
    logic          m_ovf, m_creq;
    logic [TW-1:0] m_own_tag, m_ctag;
    logic [AW-1:0] m_own_addr;
    logic [15:0]   lfsr = 16'hACE1;

    always #4 clk = ~clk;

    brtab_pred_unit u_brtab_pred_unit (
        .clk, .rst_n, .load_i, .load_tag_i, .load_addr_i,
        .pred_valid_i, .pred_tag_i, .pred_taken_i, .pred_target_i,
        .cancel_valid_i, .cancel_tag_i,
        .enable_o, .overflow_o, .cancel_req_o, .cancel_tag_o
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "enable_o", int'(enable_o), int'((m_set == 0) && !m_ovf));
        chk(req, "overflow_o", int'(overflow_o), int'(m_ovf));
        chk(req, "cancel_req_o", int'(cancel_req_o), int'(m_creq));
        if (m_creq) chk(req, "cancel_tag_o", int'(cancel_tag_o), int'(m_ctag));
    endtask

    task automatic model(input bit ld, input logic [TW-1:0] lt, input logic [AW-1:0] la,
                         input bit pv, input logic [TW-1:0] pt, input bit pk,
                         input logic [AW-1:0] pg, input bit cv, input logic [TW-1:0] ct);
        m_creq = 1'b0;
        if (ld) begin
            m_set = '0; m_ovf = 1'b0; m_own_tag = lt; m_own_addr = la;
        end else begin
            if (cv) m_set[ct] = 1'b0;
            if (pv && (pt < m_own_tag)) begin
                if (pg == m_own_addr) begin
                    if (pk) begin m_creq = 1'b1; m_ctag = pt; end
                end else if (pk) begin
                    if (!m_set[pt]) begin
                        if ($countones(m_set) < NE) m_set[pt] = 1'b1;
                        else m_ovf = 1'b1;
                    end
                end else begin
                    m_set[pt] = 1'b0;
                end
            end
        end
    endtask

    task automatic step(input string req, input bit ld, input logic [TW-1:0] lt,
                        input logic [AW-1:0] la, input bit pv, input logic [TW-1:0] pt,
                        input bit pk, input logic [AW-1:0] pg, input bit cv,
                        input logic [TW-1:0] ct);
        @(negedge clk);
        load_i = ld; load_tag_i = lt; load_addr_i = la;
        pred_valid_i = pv; pred_tag_i = pt; pred_taken_i = pk; pred_target_i = pg;
        cancel_valid_i = cv; cancel_tag_i = ct;
        @(posedge clk);
        model(ld, lt, la, pv, pt, pk, pg, cv, ct);
        #1;
        check_all(req);
    endtask

    task automatic bcast(input string req, input logic [TW-1:0] pt, input bit pk, input logic [AW-1:0] pg);
        step(req, 0, '0, '0, 1, pt, pk, pg, 0, '0);
    endtask

    task automatic cancel(input string req, input logic [TW-1:0] ct);
        step(req, 0, '0, '0, 0, '0, 0, '0, 1, ct);
    endtask

    task automatic idle(input string req);
        step(req, 0, '0, '0, 0, '0, 0, '0, 0, '0);
    endtask

    task automatic load(input string req, input logic [TW-1:0] lt, input logic [AW-1:0] la);
        step(req, 1, lt, la, 0, '0, 0, '0, 0, '0);
    endtask

    initial begin
        m_set = '0; m_ovf = 1'b0; m_creq = 1'b0; m_own_tag = '0; m_own_addr = '0; m_ctag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1");

        // Station tag 8, address 0x05
        load("R1", 4'd8, 8'h05);

        // R2: younger or equal tags ignored, sweep 8..15
        for (int t = 8; t < 16; t++) bcast("R2", TW'(t), 1, 8'h33);
        for (int t = 8; t < 16; t++) bcast("R2", TW'(t), 1, 8'h05);

        // R3 insert; R4 repeats of same tag
        bcast("R3", 4'd2, 1, 8'h33);
        for (int k = 0; k < 3; k++) bcast("R4", 4'd2, 1, 8'h44);
        bcast("R4", 4'd1, 1, 8'h33);
        bcast("R4", 4'd3, 1, 8'h33);
        bcast("R4", 4'd4, 1, 8'h33);

        // R5 not-taken clears
        bcast("R5", 4'd2, 0, 8'h33);
        // R6 cancels
        cancel("R6", 4'd9);
        cancel("R6", 4'd1);
        cancel("R6", 4'd3);
        cancel("R6", 4'd4);

        // R7 target match
        bcast("R7", 4'd6, 1, 8'h05);
        idle("R7");
        bcast("R7", 4'd6, 0, 8'h05);
        bcast("R7", 4'd5, 1, 8'h05);
        bcast("R7", 4'd5, 1, 8'h06);

        // R9 overflow
        load("R1", 4'd8, 8'h05);
        for (int t = 0; t < 5; t++) bcast("R9", TW'(t), 1, 8'h40);
        for (int t = 0; t < 5; t++) cancel("R9", TW'(t));
        bcast("R9", 4'd1, 0, 8'h40);
        idle("R9");
        load("R9", 4'd8, 8'h05);

        // R10 same-cycle cancel then predicate
        bcast("R10", 4'd7, 1, 8'h40);
        step("R10", 0, '0, '0, 1, 4'd7, 1, 8'h40, 1, 4'd7);
        step("R10", 0, '0, '0, 1, 4'd7, 0, 8'h40, 1, 4'd7);
        step("R10", 0, '0, '0, 1, 4'd6, 1, 8'h40, 1, 4'd6);

        // R11 load wins
        step("R11", 1, 4'd12, 8'h05, 1, 4'd3, 1, 8'h40, 1, 4'd6);
        step("R11", 1, 4'd12, 8'h05, 1, 4'd3, 1, 8'h05, 0, '0);
        idle("R11");

        // R8 sweep over every station tag with pseudo-random traffic
        for (int own = 0; own < 16; own++) begin
            load("R8", TW'(own), 8'h5A);
            for (int k = 0; k < 400; k++) begin
                logic [AW-1:0] tg;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tg = lfsr[9] ? 8'h5A : {4'h3, lfsr[3:0]};
                step("R8", (lfsr[15:11] == 5'd0), lfsr[7:4], 8'h5A,
                     lfsr[0], lfsr[4:1], lfsr[5] | lfsr[14], tg,
                     lfsr[6] & lfsr[8], lfsr[11:8]);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule